// File: doc/BRIEF.md
# Page-One Hardware Stack Unit

This block keeps an 8-bit stack pointer and turns push and pop requests into byte cycles on a synchronous memory port. Every stack access goes to one fixed 256-byte page of a 64 KB byte-wide address space, at the page base 0x100 plus the pointer. A processor core uses it to save and restore single bytes, such as an accumulator or status byte. It also uses it for 16-bit values such as return addresses, which are split into two byte cycles so that they sit little-endian in memory.

A push writes at the current pointer and then moves the pointer down. A pop reads at the current pointer and then moves it up. The pointer wraps within the page in both directions. A transfer instruction can overwrite the pointer in one cycle through the load input, and can read it at any time on the pointer output. Each push or pop ends with a one-cycle completion pulse. While an operation is running, new push and pop requests are dropped.

Top module: `stack_unit`

## Requirements
- R1: While reset is held, and until the first request after it is released, the pointer reads 0xFD, the completion pulse is low, the popped-data output is 0x0000 and no memory write is issued.
- R2: Every stack memory address has upper byte 0x01 and lower byte equal to the pointer at the time of that access. The pointer wraps modulo 256, so a write at pointer 0x00 is followed by an access at 0x1FF.
- R3: A byte push (push_i high, wide_i low, in an idle cycle) writes data_i[7:0] to the current pointer address in the cycle after the request. The pointer decrements by one, and done_o is high in the cycle after the write.
- R4: A byte pop (pop_i high, wide_i low) presents the current pointer address in the cycle after the request, and the pointer increments by one. Read data is taken one cycle after its address. done_o is high in the third cycle after the request, and data_o then reads {0x00, byte read}.
- R5: A word push (wide_i high) writes data_i[15:8] at the pointer in the first write cycle and data_i[7:0] at pointer-1 in the next cycle. The pointer decreases by two, and done_o is high in the cycle after the second write.
- R6: A word pop reads a first byte at the pointer and a second byte at pointer+1 in consecutive cycles. The pointer increases by two, and done_o is high in the fourth cycle after the request, with data_o = {second byte, first byte}.
- R7: load_i in an idle cycle replaces the pointer with load_val_i at the next clock edge, with no memory write and no completion pulse. When load_i, push_i and pop_i are high together, load_i wins.
- R8: done_o is high for exactly one cycle per push or pop. data_o keeps its value until the next pop completes.
- R9: Push, pop and load requests that arrive while an operation is running are ignored, including in the cycle where it is finishing. The pointer and memory end up as if the requests had not occurred.
- R10: If push_i and pop_i are high together in an idle cycle without load_i, the request is a push.
- R11: A pop at pointer 0xFF reads from 0x1FF, and the pointer then wraps to 0x00. A word pop there takes its second byte from 0x100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_i | input | 1 | Push request strobe |
| pop_i | input | 1 | Pop request strobe |
| wide_i | input | 1 | Operation width: 0 byte, 1 sixteen-bit |
| load_i | input | 1 | Replace the pointer with load_val_i |
| load_val_i | input | 8 | New pointer value |
| data_i | input | 16 | Value to push (low byte only for byte pushes) |
| data_o | output | 16 | Value from the last completed pop |
| done_o | output | 1 | One-cycle completion pulse |
| sp_o | output | 8 | Current stack pointer |
| mem_addr_o | output | 16 | Memory address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_we_o | output | 1 | Memory write enable |
| mem_rdata_i | input | 8 | Memory read data, valid one cycle after its address |

## Verification
The assertions assume the memory returns read data exactly one cycle after its address and that reset is held for at least one clock edge. They also assume the request strobes are sampled only at clock edges, so a strobe that stays high across a completion cycle counts as a new request once the unit is idle. The bench drives every strobe for exactly one cycle from the falling edge. The only deliberate exception is the busy-window test, which drops its extra strobes before the unit returns to idle. The bench memory model has the one-cycle read latency the unit expects.

// File: rtl/stack_pkg.sv
package stack_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_PUSH_A = 3'd1,
        ST_PUSH_B = 3'd2,
        ST_POP_A  = 3'd3,
        ST_POP_B  = 3'd4,
        ST_CAP    = 3'd5
    } stk_state_e;
endpackage

// File: rtl/stack_ptr.sv
module stack_ptr #(
    parameter int PTR_W = 8,
    parameter logic [PTR_W-1:0] RESET_PTR = 'hFD
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [PTR_W-1:0] load_val_i,
    input  logic             dec_i,
    input  logic             inc_i,
    output logic [PTR_W-1:0] sp_o
);
    typedef struct packed {
        logic [PTR_W-1:0] sp;
    } ptr_reg_t;

    ptr_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (load_i) begin
            r_d.sp = load_val_i;
        end else if (dec_i) begin
            r_d.sp = r_q.sp - 1'b1;
        end else if (inc_i) begin
            r_d.sp = r_q.sp + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.sp <= RESET_PTR;
        end else begin
            r_q <= r_d;
        end
    end

    assign sp_o = r_q.sp;
endmodule

// File: rtl/stack_seq.sv
module stack_seq
    import stack_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic push_i,
    input  logic pop_i,
    input  logic wide_i,
    input  logic load_i,
    output logic busy_o,
    output logic accept_push_o,
    output logic ptr_load_o,
    output logic ptr_dec_o,
    output logic ptr_inc_o,
    output logic mem_we_o,
    output logic mem_rd_o,
    output logic wr_hi_o,
    output logic cap_first_o,
    output logic cap_last_o,
    output logic wide_o,
    output logic done_o
);
    typedef struct packed {
        stk_state_e state;
        logic       wide;
        logic       done;
    } seq_reg_t;

    seq_reg_t r_d, r_q;

    always_comb begin
        r_d           = r_q;
        r_d.done      = 1'b0;
        accept_push_o = 1'b0;
        ptr_load_o    = 1'b0;
        ptr_dec_o     = 1'b0;
        ptr_inc_o     = 1'b0;
        mem_we_o      = 1'b0;
        mem_rd_o      = 1'b0;
        wr_hi_o       = 1'b0;
        cap_first_o   = 1'b0;
        cap_last_o    = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (load_i) begin
                    ptr_load_o = 1'b1;
                end else if (push_i) begin
                    accept_push_o = 1'b1;
                    r_d.wide      = wide_i;
                    r_d.state     = ST_PUSH_A;
                end else if (pop_i) begin
                    r_d.wide  = wide_i;
                    r_d.state = ST_POP_A;
                end
            end
            ST_PUSH_A: begin
                mem_we_o  = 1'b1;
                wr_hi_o   = r_q.wide;
                ptr_dec_o = 1'b1;
                if (r_q.wide) begin
                    r_d.state = ST_PUSH_B;
                end else begin
                    r_d.state = ST_IDLE;
                    r_d.done  = 1'b1;
                end
            end
            ST_PUSH_B: begin
                mem_we_o  = 1'b1;
                ptr_dec_o = 1'b1;
                r_d.state = ST_IDLE;
                r_d.done  = 1'b1;
            end
            ST_POP_A: begin
                mem_rd_o  = 1'b1;
                ptr_inc_o = 1'b1;
                r_d.state = r_q.wide ? ST_POP_B : ST_CAP;
            end
            ST_POP_B: begin
                mem_rd_o    = 1'b1;
                ptr_inc_o   = 1'b1;
                cap_first_o = 1'b1;
                r_d.state   = ST_CAP;
            end
            ST_CAP: begin
                cap_last_o = 1'b1;
                r_d.done   = 1'b1;
                r_d.state  = ST_IDLE;
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
            r_q.wide  <= 1'b0;
            r_q.done  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o = (r_q.state != ST_IDLE);
    assign wide_o = r_q.wide;
    assign done_o = r_q.done;
endmodule

// File: rtl/stack_data.sv
module stack_data #(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                accept_push_i,
    input  logic [2*BYTE_W-1:0] push_val_i,
    input  logic                wr_hi_i,
    input  logic                cap_first_i,
    input  logic                cap_last_i,
    input  logic                wide_i,
    input  logic [BYTE_W-1:0]   rdata_i,
    output logic [BYTE_W-1:0]   wdata_o,
    output logic [2*BYTE_W-1:0] pop_val_o
);
    localparam int WORD_W = 2 * BYTE_W;

    typedef struct packed {
        logic [WORD_W-1:0] wbuf;
        logic [BYTE_W-1:0] lo;
        logic [BYTE_W-1:0] hi;
    } data_reg_t;

    data_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (accept_push_i) begin
            r_d.wbuf = push_val_i;
        end
        if (cap_first_i) begin
            r_d.lo = rdata_i;
        end
        if (cap_last_i) begin
            if (wide_i) begin
                r_d.hi = rdata_i;
            end else begin
                r_d.lo = rdata_i;
                r_d.hi = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign wdata_o   = wr_hi_i ? r_q.wbuf[WORD_W-1:BYTE_W] : r_q.wbuf[BYTE_W-1:0];
    assign pop_val_o = {r_q.hi, r_q.lo};
endmodule

// File: rtl/stack_unit.sv
module stack_unit #(
    parameter int PTR_W = 8,
    parameter int PAGE_W = 8,
    parameter int BYTE_W = 8,
    parameter logic [PAGE_W-1:0] PAGE_NUM = 'h01,
    parameter logic [PTR_W-1:0] RESET_PTR = 'hFD,
    localparam int ADDR_W = PAGE_W + PTR_W,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic              wide_i,
    input  logic              load_i,
    input  logic [PTR_W-1:0]  load_val_i,
    input  logic [WORD_W-1:0] data_i,
    output logic [WORD_W-1:0] data_o,
    output logic              done_o,
    output logic [PTR_W-1:0]  sp_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [BYTE_W-1:0] mem_wdata_o,
    output logic              mem_we_o,
    input  logic [BYTE_W-1:0] mem_rdata_i
);
    logic busy, accept_push, ptr_load, ptr_dec, ptr_inc;
    logic rd_issue, wr_hi, cap_first, cap_last, wide_q;

    stack_seq u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .push_i        (push_i),
        .pop_i         (pop_i),
        .wide_i        (wide_i),
        .load_i        (load_i),
        .busy_o        (busy),
        .accept_push_o (accept_push),
        .ptr_load_o    (ptr_load),
        .ptr_dec_o     (ptr_dec),
        .ptr_inc_o     (ptr_inc),
        .mem_we_o      (mem_we_o),
        .mem_rd_o      (rd_issue),
        .wr_hi_o       (wr_hi),
        .cap_first_o   (cap_first),
        .cap_last_o    (cap_last),
        .wide_o        (wide_q),
        .done_o        (done_o)
    );

    stack_ptr #(.PTR_W(PTR_W), .RESET_PTR(RESET_PTR)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (ptr_load),
        .load_val_i (load_val_i),
        .dec_i      (ptr_dec),
        .inc_i      (ptr_inc),
        .sp_o       (sp_o)
    );

    stack_data #(.BYTE_W(BYTE_W)) u_data (
        .clk           (clk),
        .rst_n         (rst_n),
        .accept_push_i (accept_push),
        .push_val_i    (data_i),
        .wr_hi_i       (wr_hi),
        .cap_first_i   (cap_first),
        .cap_last_i    (cap_last),
        .wide_i        (wide_q),
        .rdata_i       (mem_rdata_i),
        .wdata_o       (mem_wdata_o),
        .pop_val_o     (data_o)
    );

    assign mem_addr_o = {PAGE_NUM, sp_o};
endmodule

// File: rtl/stack_unit_chk.sv
module stack_unit_chk #(
    parameter int PTR_W = 8,
    parameter logic [PTR_W-1:0] RESET_PTR = 'hFD
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load_i,
    input logic [PTR_W-1:0] load_val_i,
    input logic [PTR_W-1:0] sp_o,
    input logic             mem_we_o,
    input logic             rd_issue,
    input logic             busy,
    input logic             done_o
);
    // R1: pointer value straight after reset is released
    p_reset_ptr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (sp_o == RESET_PTR));

    // R3: every write cycle moves the pointer down by one
    p_write_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |=> (sp_o == PTR_W'($past(sp_o) - 1'b1)));

    // R4: every read cycle moves the pointer up by one
    p_read_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_issue |=> (sp_o == PTR_W'($past(sp_o) + 1'b1)));

    // R7: idle load replaces the pointer
    p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && load_i) |=> (sp_o == $past(load_val_i)));

    // R8: completion is a single-cycle pulse
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9: a load while busy does not disturb the pointer beyond the operation
    p_busy_noload_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_we_o && !rd_issue) |=> $stable(sp_o));
endmodule

bind stack_unit stack_unit_chk #(.PTR_W(PTR_W), .RESET_PTR(RESET_PTR)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load_i),
    .load_val_i (load_val_i),
    .sp_o       (sp_o),
    .mem_we_o   (mem_we_o),
    .rd_issue   (rd_issue),
    .busy       (busy),
    .done_o     (done_o)
);

// File: tb/tb_stack_unit.sv
`timescale 1ns/1ps
module tb_stack_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_i = 1'b0, pop_i = 1'b0, wide_i = 1'b0, load_i = 1'b0;
    logic [7:0]  load_val_i = '0;
    logic [15:0] data_i = '0;
    logic [15:0] data_o;
    logic        done_o;
    logic [7:0]  sp_o;
    logic [15:0] mem_addr_o;
    logic [7:0]  mem_wdata_o;
    logic        mem_we_o;
    logic [7:0]  mem_rdata_i;

    int checks = 0;
    int failures = 0;
    logic [7:0] mem [256];
    logic [7:0] sp_m;

    always #4 clk = ~clk;

    stack_unit dut (
        .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i), .wide_i(wide_i),
        .load_i(load_i), .load_val_i(load_val_i), .data_i(data_i), .data_o(data_o),
        .done_o(done_o), .sp_o(sp_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
        .mem_we_o(mem_we_o), .mem_rdata_i(mem_rdata_i)
    );

    always_ff @(posedge clk) begin
        if (mem_we_o) mem[mem_addr_o[7:0]] <= mem_wdata_o;
        mem_rdata_i <= mem[mem_addr_o[7:0]];
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic t_push_byte(input logic [7:0] v, input string req);
        push_i = 1'b1; wide_i = 1'b0; data_i = {8'h00, v};
        tick(); push_i = 1'b0;
        chk({req, " we"}, 16'(mem_we_o), 16'd1);
        chk({req, " addr"}, mem_addr_o, {8'h01, sp_m});
        chk({req, " wdata"}, 16'(mem_wdata_o), 16'(v));
        tick();
        chk({req, " done"}, 16'(done_o), 16'd1);
        chk({req, " mem"}, 16'(mem[sp_m]), 16'(v));
        sp_m = sp_m - 8'd1;
        chk({req, " sp"}, 16'(sp_o), 16'(sp_m));
    endtask

    task automatic t_push_word(input logic [15:0] v, input string req);
        push_i = 1'b1; wide_i = 1'b1; data_i = v;
        tick(); push_i = 1'b0;
        chk({req, " addr hi"}, mem_addr_o, {8'h01, sp_m});
        chk({req, " wdata hi"}, 16'(mem_wdata_o), 16'(v[15:8]));
        tick();
        chk({req, " addr lo"}, mem_addr_o, {8'h01, 8'(sp_m - 8'd1)});
        chk({req, " wdata lo"}, 16'(mem_wdata_o), 16'(v[7:0]));
        chk({req, " early done"}, 16'(done_o), 16'd0);
        tick();
        chk({req, " done"}, 16'(done_o), 16'd1);
        chk({req, " mem"}, {mem[8'(sp_m - 8'd1)], mem[sp_m]}, {v[7:0], v[15:8]});
        sp_m = sp_m - 8'd2;
        chk({req, " sp"}, 16'(sp_o), 16'(sp_m));
    endtask

    task automatic t_pop_byte(input string req);
        logic [7:0] e;
        e = mem[sp_m];
        pop_i = 1'b1; wide_i = 1'b0;
        tick(); pop_i = 1'b0;
        chk({req, " addr"}, mem_addr_o, {8'h01, sp_m});
        tick();
        chk({req, " early done"}, 16'(done_o), 16'd0);
        tick();
        chk({req, " done"}, 16'(done_o), 16'd1);
        chk({req, " data"}, data_o, {8'h00, e});
        sp_m = sp_m + 8'd1;
        chk({req, " sp"}, 16'(sp_o), 16'(sp_m));
    endtask

    task automatic t_pop_word(input logic [15:0] exp, input string req);
        pop_i = 1'b1; wide_i = 1'b1;
        tick(); pop_i = 1'b0;
        tick(); tick();
        chk({req, " early done"}, 16'(done_o), 16'd0);
        tick();
        chk({req, " done"}, 16'(done_o), 16'd1);
        chk({req, " data"}, data_o, exp);
        sp_m = sp_m + 8'd2;
        chk({req, " sp"}, 16'(sp_o), 16'(sp_m));
    endtask

    task automatic t_load(input logic [7:0] v, input string req);
        load_i = 1'b1; load_val_i = v;
        tick(); load_i = 1'b0;
        sp_m = v;
        chk({req, " sp"}, 16'(sp_o), 16'(v));
        chk({req, " no write"}, 16'(mem_we_o), 16'd0);
        tick();
        chk({req, " no done"}, 16'(done_o), 16'd0);
    endtask

    task automatic t_load_beats_push();
        logic [7:0] keep;
        keep = mem[8'h80];
        load_i = 1'b1; load_val_i = 8'h80; push_i = 1'b1; pop_i = 1'b1;
        wide_i = 1'b0; data_i = 16'h00C3;
        tick(); load_i = 1'b0; push_i = 1'b0; pop_i = 1'b0;
        sp_m = 8'h80;
        chk("R7 load priority sp", 16'(sp_o), 16'h0080);
        chk("R7 load priority no write", 16'(mem_we_o), 16'd0);
        tick();
        chk("R7 load priority no done", 16'(done_o), 16'd0);
        chk("R7 load priority mem", 16'(mem[8'h80]), 16'(keep));
    endtask

    task automatic t_push_over_pop();
        push_i = 1'b1; pop_i = 1'b1; wide_i = 1'b0; data_i = 16'h0077;
        tick(); push_i = 1'b0; pop_i = 1'b0;
        chk("R10 write issued", 16'(mem_we_o), 16'd1);
        tick();
        chk("R10 done", 16'(done_o), 16'd1);
        chk("R10 mem", 16'(mem[sp_m]), 16'h0077);
        sp_m = sp_m - 8'd1;
        chk("R10 sp", 16'(sp_o), 16'(sp_m));
    endtask

    task automatic t_busy_ignore();
        logic [7:0] below;
        below = mem[8'(sp_m - 8'd2)];
        push_i = 1'b1; wide_i = 1'b1; data_i = 16'hA1B2;
        tick();
        // unit now busy: hold a pop and a push and a load through the busy window
        push_i = 1'b1; pop_i = 1'b1; load_i = 1'b1; load_val_i = 8'h10; wide_i = 1'b0;
        tick(); tick();
        push_i = 1'b0; pop_i = 1'b0; load_i = 1'b0;
        chk("R9 done", 16'(done_o), 16'd1);
        sp_m = sp_m - 8'd2;
        chk("R9 sp", 16'(sp_o), 16'(sp_m));
        tick();
        chk("R9 no extra done", 16'(done_o), 16'd0);
        chk("R9 no extra write", 16'(mem_we_o), 16'd0);
        chk("R9 sp stable", 16'(sp_o), 16'(sp_m));
        chk("R9 mem untouched", 16'(mem[sp_m]), 16'(below));
    endtask

    task automatic t_done_hold();
        logic [15:0] held;
        held = data_o;
        tick();
        chk("R8 pulse low", 16'(done_o), 16'd0);
        t_push_byte(8'h3C, "R8 push");
        chk("R8 data held", data_o, held);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5C;
        repeat (3) tick();
        chk("R1 sp in reset", 16'(sp_o), 16'h00FD);
        rst_n = 1'b1;
        tick();
        chk("R1 sp", 16'(sp_o), 16'h00FD);
        chk("R1 done", 16'(done_o), 16'd0);
        chk("R1 data", data_o, 16'h0000);
        chk("R1 we", 16'(mem_we_o), 16'd0);
        sp_m = 8'hFD;

        t_push_byte(8'hA5, "R3 R2 byte push");
        t_push_word(16'h1234, "R5 word push");
        t_pop_word({8'h34, mem[8'hFA]}, "R6 word pop");
        t_pop_byte("R4 byte pop");
        chk("R4 byte value", data_o, 16'h0012);

        t_load(8'h00, "R7 load");
        t_push_word(16'hBEEF, "R2 wrap push");
        t_pop_byte("R4 pop at FE");
        t_pop_word(16'hBEEF, "R11 wrap pop");

        t_load_beats_push();
        t_push_over_pop();
        t_busy_ignore();
        t_pop_byte("R8 pop");
        t_done_hold();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=hung expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule